// File: doc/BRIEF.md
# Tear-Safe Journaled Write Sequencer

This block sequences every write into a small nonvolatile byte array so that a write cut short by a power loss can be finished later. The host presents an address, a byte count and up to sixteen bytes of data in one request. With the safe mode off the bytes go straight to their destination. With the safe mode on, the bytes are first stored in a reserved journal region together with the destination address and the count. A commit mark is then written, the bytes are copied from the journal to the destination, and finally the mark is erased.

On every power-up (reset release) the sequencer inspects the commit mark. A set mark means the copy stage was interrupted, so the recorded copy is replayed before any new request is taken. A clear mark means any tear happened before the journal was complete; the destination was never touched and the record is ignored. The array cells keep their contents across reset; each internal byte write takes a fixed, parameterised number of clock cycles, and a reset during that window loses that byte.

Top module: `tsw_ctrl`

## Requirements
- R1: After reset release with no committed journal record, `busy` falls within two cycles, no pulse appears on `req_ack`, `req_nack` or `len_err`, and the user bytes are unchanged.
- R2: With `req_safe`=0, a request of 1 to MAX_LEN bytes writes byte i of `req_data` (bits 8i+7..8i) to user address `req_addr`+i, touching no other user byte.
- R3: With `req_safe`=1, a request of 1 to SAFE_MAX bytes ends with the same destination contents as R2 would give.
- R4: A request with length 0, length above SAFE_MAX in safe mode, length above MAX_LEN in direct mode, or `req_addr`+length above USER_DEPTH gives a one-cycle `len_err` pulse in the cycle after the request, no `req_ack`, `busy` stays low, and no user byte changes.
- R5: For the same length, a safe-mode write keeps `busy` high for more cycles than a direct write.
- R6: A request presented while `busy` is high gives a one-cycle `req_nack` in the next cycle and is discarded; the write in progress completes unaltered.
- R7: A reset asserted after the copy stage has started is followed, on release, by a replay that keeps `busy` high and leaves every destination byte of the interrupted request holding its new value.
- R8: A reset asserted while the journal is still being filled leaves all destination bytes at their old values, and the following boot performs no replay.
- R9: A completed write or replay erases the commit mark, so a later reset performs no replay (`busy` falls within two cycles).
- R10: An accepted request gives a one-cycle `req_ack` in the cycle after the request, with `busy` already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; models power-up |
| req_valid | input | 1 | Write request strobe |
| req_safe | input | 1 | 1 = journaled write, 0 = direct write |
| req_addr | input | ADDR_W | First destination byte address |
| req_len | input | LEN_W | Number of bytes to write |
| req_data | input | MAX_LEN*8 | Write bytes, byte i in bits 8i+7..8i |
| req_ack | output | 1 | Request accepted pulse |
| req_nack | output | 1 | Request refused because busy |
| len_err | output | 1 | Request rejected by the length/range check |
| busy | output | 1 | Sequencer is writing or replaying |
| rd_addr | input | ADDR_W | User byte readback address |
| rd_data | output | 8 | User byte at `rd_addr` (combinational) |

## Verification
Two events can land on the same clock edge: a host request and an ongoing internal write or replay, and a power loss and the completion of a byte write in the array. The first is provoked by pulsing a request a few cycles into a journaled write and judged by the refusal pulse and by the array contents afterwards matching only the first request. The second is provoked by watching the destination through the readback port and pulling reset on the cycle the first copied byte appears; the replayed contents and the short boot of a later reset show whether the commit mark was handled in the right order.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [3:0] {
        S_BOOT_CHK,
        S_BOOT_ADR,
        S_BOOT_CNT,
        S_IDLE,
        S_JDATA,
        S_JADDR,
        S_JCNT,
        S_JMARK,
        S_COPY,
        S_JCLR
    } seq_state_e;

    // value stored in the journal mark cell once a record is complete
    localparam logic [7:0] COMMIT_MARK = 8'hA5;

endpackage

// File: rtl/tsw_nvm.sv
module tsw_nvm #(
    parameter int DEPTH  = 80,
    parameter int WR_LAT = 4,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          wr_busy,
    output logic          wr_done,
    input  logic [AW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [7:0]    rb_data
);

    localparam int CW    = (WR_LAT > 1) ? $clog2(WR_LAT + 1) : 1;
    localparam int CELLS = 2 ** AW;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          done;
    } nvm_st_t;

    nvm_st_t    st_d, st_q;
    logic       commit;
    logic [7:0] cells [CELLS];

    // cells start erased; they are never cleared by reset
    initial begin
        for (int i = 0; i < CELLS; i++) cells[i] = 8'h00;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        commit    = st_q.busy && (st_q.cnt == '0) && rst_n;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (wr_go) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(WR_LAT - 1);
            st_d.addr = wr_addr;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (commit) cells[st_q.addr] <= st_q.data;
    end

    assign wr_busy = st_q.busy;
    assign wr_done = st_q.done;
    assign ra_data = cells[ra_addr];
    assign rb_data = cells[rb_addr];

    // R6: the sequencer never starts a write while one is in flight
    p_go_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !st_q.busy);

    // completion is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

endmodule

// File: rtl/tsw_lenchk.sv
module tsw_lenchk #(
    parameter int USER_DEPTH = 64,
    parameter int MAX_LEN    = 16,
    parameter int SAFE_MAX   = 8,
    parameter int ADDR_W     = 6,
    parameter int LEN_W      = 5
) (
    input  logic              safe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              bad
);

    int limit;

    always_comb begin
        limit = safe ? SAFE_MAX : MAX_LEN;
        bad   = (len == '0)
             || (int'(len) > limit)
             || ((int'(addr) + int'(len)) > USER_DEPTH);
    end

endmodule

// File: rtl/tsw_seq.sv
module tsw_seq
    import tsw_pkg::*;
#(
    parameter int USER_DEPTH = 64,
    parameter int MAX_LEN    = 16,
    parameter int SAFE_MAX   = 8,
    parameter int ADDR_W     = 6,
    parameter int LEN_W      = 5,
    parameter int NV_AW      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_safe,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [MAX_LEN*8-1:0] req_data,
    input  logic                 len_bad,
    output logic                 req_ack,
    output logic                 req_nack,
    output logic                 len_err,
    output logic                 busy,
    output logic                 wr_go,
    output logic [NV_AW-1:0]     wr_addr,
    output logic [7:0]           wr_data,
    input  logic                 wr_done,
    output logic [NV_AW-1:0]     rb_addr,
    input  logic [7:0]           rb_data
);

    // journal layout above the user region
    localparam int JBASE  = USER_DEPTH;
    localparam int J_ADDR = JBASE + SAFE_MAX;
    localparam int J_CNT  = JBASE + SAFE_MAX + 1;
    localparam int J_MARK = JBASE + SAFE_MAX + 2;

    typedef struct packed {
        seq_state_e           state;
        logic [LEN_W-1:0]     idx;
        logic [LEN_W-1:0]     len;
        logic [ADDR_W-1:0]    addr;
        logic [MAX_LEN*8-1:0] bytes;
        logic                 from_j;
        logic                 issued;
        logic                 ack;
        logic                 nack;
        logic                 err;
    } seq_st_t;

    seq_st_t q, d;
    logic    last;
    logic    is_wr_state;

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        d.nack   = 1'b0;
        d.err    = 1'b0;
        wr_go    = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        rb_addr  = NV_AW'(J_MARK);
        last     = (q.idx == (q.len - 1'b1));
        is_wr_state = 1'b0;

        if (req_valid && (q.state != S_IDLE)) d.nack = 1'b1;

        case (q.state)
            S_BOOT_CHK: begin
                rb_addr = NV_AW'(J_MARK);
                d.state = (rb_data == COMMIT_MARK) ? S_BOOT_ADR : S_IDLE;
            end
            S_BOOT_ADR: begin
                rb_addr = NV_AW'(J_ADDR);
                d.addr  = rb_data[ADDR_W-1:0];
                d.state = S_BOOT_CNT;
            end
            S_BOOT_CNT: begin
                rb_addr = NV_AW'(J_CNT);
                if ((rb_data != 8'h00) && (int'(rb_data) <= SAFE_MAX)) begin
                    d.len    = rb_data[LEN_W-1:0];
                    d.idx    = '0;
                    d.from_j = 1'b1;
                    d.issued = 1'b0;
                    d.state  = S_COPY;
                end else begin
                    d.state = S_IDLE;
                end
            end
            S_IDLE: begin
                if (req_valid) begin
                    if (len_bad) begin
                        d.err = 1'b1;
                    end else begin
                        d.ack    = 1'b1;
                        d.addr   = req_addr;
                        d.len    = req_len;
                        d.bytes  = req_data;
                        d.idx    = '0;
                        d.from_j = req_safe;
                        d.issued = 1'b0;
                        d.state  = req_safe ? S_JDATA : S_COPY;
                    end
                end
            end
            S_JDATA: begin
                is_wr_state = 1'b1;
                wr_addr = NV_AW'(JBASE) + NV_AW'(q.idx);
                wr_data = q.bytes[8*int'(q.idx) +: 8];
            end
            S_JADDR: begin
                is_wr_state = 1'b1;
                wr_addr = NV_AW'(J_ADDR);
                wr_data = 8'(q.addr);
            end
            S_JCNT: begin
                is_wr_state = 1'b1;
                wr_addr = NV_AW'(J_CNT);
                wr_data = 8'(q.len);
            end
            S_JMARK: begin
                is_wr_state = 1'b1;
                wr_addr = NV_AW'(J_MARK);
                wr_data = COMMIT_MARK;
            end
            S_COPY: begin
                is_wr_state = 1'b1;
                rb_addr = NV_AW'(JBASE) + NV_AW'(q.idx);
                wr_addr = NV_AW'(q.addr) + NV_AW'(q.idx);
                wr_data = q.from_j ? rb_data : q.bytes[8*int'(q.idx) +: 8];
            end
            S_JCLR: begin
                is_wr_state = 1'b1;
                wr_addr = NV_AW'(J_MARK);
                wr_data = 8'h00;
            end
            default: d.state = S_IDLE;
        endcase

        // common issue / completion handshake with the array
        if (is_wr_state) begin
            if (!q.issued) begin
                wr_go    = 1'b1;
                d.issued = 1'b1;
            end else if (wr_done) begin
                d.issued = 1'b0;
                case (q.state)
                    S_JDATA: begin
                        if (last) d.state = S_JADDR;
                        else      d.idx   = q.idx + 1'b1;
                    end
                    S_JADDR: d.state = S_JCNT;
                    S_JCNT:  d.state = S_JMARK;
                    S_JMARK: begin
                        d.idx    = '0;
                        d.from_j = 1'b1;
                        d.state  = S_COPY;
                    end
                    S_COPY: begin
                        if (last) d.state = q.from_j ? S_JCLR : S_IDLE;
                        else      d.idx   = q.idx + 1'b1;
                    end
                    default: d.state = S_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_BOOT_CHK;
        end else begin
            q <= d;
        end
    end

    assign req_ack  = q.ack;
    assign req_nack = q.nack;
    assign len_err  = q.err;
    assign busy     = (q.state != S_IDLE);

    // R6: a request during a write or replay is refused next cycle
    p_nack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> req_nack);

    // R4: a rejected request is never also accepted
    p_err_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !req_ack);

    // R4: a rejected request starts nothing
    p_err_stays_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && len_bad) |=> (len_err && !busy));

    // R10: acceptance always coincides with the sequencer running
    p_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> busy);

endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl #(
    parameter int USER_DEPTH = 64,
    parameter int MAX_LEN    = 16,
    parameter int SAFE_MAX   = 8,
    parameter int WR_LAT     = 4,
    parameter int ADDR_W     = $clog2(USER_DEPTH),
    parameter int LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_safe,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [MAX_LEN*8-1:0] req_data,
    output logic                 req_ack,
    output logic                 req_nack,
    output logic                 len_err,
    output logic                 busy,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data
);

    localparam int NV_DEPTH = USER_DEPTH + SAFE_MAX + 3;
    localparam int NV_AW    = $clog2(NV_DEPTH);

    logic             len_bad;
    logic             wr_go;
    logic [NV_AW-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic             wr_busy;
    logic             wr_done;
    logic [NV_AW-1:0] rb_addr;
    logic [7:0]       rb_data;

    tsw_lenchk #(
        .USER_DEPTH (USER_DEPTH),
        .MAX_LEN    (MAX_LEN),
        .SAFE_MAX   (SAFE_MAX),
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W)
    ) i_lenchk (
        .safe (req_safe),
        .addr (req_addr),
        .len  (req_len),
        .bad  (len_bad)
    );

    tsw_seq #(
        .USER_DEPTH (USER_DEPTH),
        .MAX_LEN    (MAX_LEN),
        .SAFE_MAX   (SAFE_MAX),
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .NV_AW      (NV_AW)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_safe  (req_safe),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_data  (req_data),
        .len_bad   (len_bad),
        .req_ack   (req_ack),
        .req_nack  (req_nack),
        .len_err   (len_err),
        .busy      (busy),
        .wr_go     (wr_go),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_done   (wr_done),
        .rb_addr   (rb_addr),
        .rb_data   (rb_data)
    );

    tsw_nvm #(
        .DEPTH  (NV_DEPTH),
        .WR_LAT (WR_LAT),
        .AW     (NV_AW)
    ) i_nvm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_busy (wr_busy),
        .wr_done (wr_done),
        .ra_addr (NV_AW'(rd_addr)),
        .ra_data (rd_data),
        .rb_addr (rb_addr),
        .rb_data (rb_data)
    );

    // R2: the array never reports completion without a write in flight
    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(wr_busy));

endmodule

// File: tb/test_tsw_ctrl.sv
module test_tsw_ctrl;

    localparam int UD = 64;
    localparam int ML = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_safe = 1'b0;
    logic [5:0]   req_addr = '0;
    logic [4:0]   req_len = '0;
    logic [127:0] req_data = '0;
    logic         req_ack, req_nack, len_err, busy;
    logic [5:0]   rd_addr;
    logic [7:0]   rd_data;

    logic         mon_on = 1'b0;
    logic [5:0]   mon_addr = '0;
    logic [5:0]   poll_addr = '0;
    assign rd_addr = mon_on ? mon_addr : poll_addr;

    tsw_ctrl i_tsw_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_safe(req_safe),
        .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
        .req_ack(req_ack), .req_nack(req_nack), .len_err(len_err), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        int         a;
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t       sbq[$];
    logic [7:0] shadow [UD];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         ended = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // scoreboard monitor: compares queued expectations through the readback port
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t it;
                it = sbq.pop_front();
                mon_on = 1'b1;
                mon_addr = 6'(it.a);
                #2;
                check(rd_data == it.v, it.tag, $sformatf("byte[%0d]", it.a),
                      int'(rd_data), int'(it.v));
                mon_on = 1'b0;
            end
        end
    end

    task automatic push_all(input string tag);
        for (int a = 0; a < UD; a++) begin
            exp_t it;
            it.a = a; it.v = shadow[a]; it.tag = tag;
            sbq.push_back(it);
        end
        wait (sbq.size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [127:0] pat(input logic [7:0] base);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = base + 8'(i);
        return r;
    endfunction

    task automatic apply(input int addr, input int len, input logic [127:0] data);
        for (int i = 0; i < len; i++) shadow[addr + i] = data[8*i +: 8];
    endtask

    task automatic issue(input int addr, input int len, input bit safe,
                         input logic [127:0] data,
                         output bit acked, output bit errd, output int cyc);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_safe = safe; req_addr = 6'(addr);
        req_len = 5'(len); req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        acked = req_ack; errd = len_err;
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic power_cycle(output int boot_cyc);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        boot_cyc = 0;
        while (busy && boot_cyc < 5000) begin
            boot_cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        bit acked, errd;
        int cyc, cyc_d8, cyc_s8, boot;

        for (int a = 0; a < UD; a++) shadow[a] = 8'h00;

        // R1: reset and boot with an empty journal
        repeat (4) @(negedge clk);
        check(!req_ack && !req_nack && !len_err, "R1", "pulses in reset",
              {req_ack, req_nack, len_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc = 0;
        while (busy && cyc < 100) begin cyc++; @(negedge clk); end
        check(cyc <= 2, "R1", "boot cycles", cyc, 2);
        push_all("R1");

        // R2: direct writes, full page and top-edge single byte
        issue(3, 16, 1'b0, pat(8'h10), acked, errd, cyc);
        check(acked && !errd, "R2", "accept", {acked, errd}, 2);
        apply(3, 16, pat(8'h10));
        issue(63, 1, 1'b0, pat(8'h3C), acked, errd, cyc);
        apply(63, 1, pat(8'h3C));
        push_all("R2");

        // R3 / R5: journaled writes against a direct write of equal length
        issue(40, 8, 1'b0, pat(8'h60), acked, errd, cyc_d8);
        apply(40, 8, pat(8'h60));
        issue(20, 8, 1'b1, pat(8'h40), acked, errd, cyc_s8);
        check(acked && !errd, "R10", "safe accept", {acked, errd}, 2);
        apply(20, 8, pat(8'h40));
        issue(0, 1, 1'b1, pat(8'h77), acked, errd, cyc);
        apply(0, 1, pat(8'h77));
        push_all("R3");
        check(cyc_s8 > cyc_d8, "R5", "safe busy longer", cyc_s8, cyc_d8 + 1);

        // R4: rejected requests
        issue(30, 9, 1'b1, pat(8'h90), acked, errd, cyc);
        check(errd && !acked && cyc == 0, "R4", "safe len 9", {errd, acked}, 2);
        issue(30, 17, 1'b0, pat(8'h91), acked, errd, cyc);
        check(errd && !acked && cyc == 0, "R4", "direct len 17", {errd, acked}, 2);
        issue(30, 0, 1'b0, pat(8'h92), acked, errd, cyc);
        check(errd && !acked && cyc == 0, "R4", "len 0", {errd, acked}, 2);
        issue(60, 8, 1'b1, pat(8'h93), acked, errd, cyc);
        check(errd && !acked && cyc == 0, "R4", "range end", {errd, acked}, 2);
        push_all("R4");

        // R6: request during a journaled write is refused
        @(negedge clk);
        req_valid = 1'b1; req_safe = 1'b1; req_addr = 6'd48; req_len = 5'd4;
        req_data = pat(8'hA0);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ack, "R10", "ack pulse", int'(req_ack), 1);
        check(busy, "R10", "busy with ack", int'(busy), 1);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_safe = 1'b0; req_addr = 6'd56; req_len = 5'd4;
        req_data = pat(8'hB0);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_nack, "R6", "nack pulse", int'(req_nack), 1);
        @(negedge clk);
        check(!req_nack, "R6", "nack single cycle", int'(req_nack), 0);
        while (busy) @(negedge clk);
        apply(48, 4, pat(8'hA0));
        push_all("R6");

        // R7: tear after the copy stage started, then replay on boot
        poll_addr = 6'd30;
        @(negedge clk);
        req_valid = 1'b1; req_safe = 1'b1; req_addr = 6'd30; req_len = 5'd6;
        req_data = pat(8'h80);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (rd_data != 8'h80 && cyc < 2000) begin cyc++; @(negedge clk); end
        rst_n = 1'b0;
        poll_addr = 6'd35;
        #1;
        check(rd_data == 8'h00, "R7", "tail not yet copied", int'(rd_data), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        boot = 0;
        while (busy && boot < 5000) begin boot++; @(negedge clk); end
        check(boot > 10, "R7", "replay busy cycles", boot, 11);
        apply(30, 6, pat(8'h80));
        push_all("R7");

        // R9: record erased, next boot is short
        power_cycle(boot);
        check(boot <= 2, "R9", "boot after replay", boot, 2);
        push_all("R9");

        // R8: tear while the journal is being filled
        @(negedge clk);
        req_valid = 1'b1; req_safe = 1'b1; req_addr = 6'd50; req_len = 5'd4;
        req_data = pat(8'hC0);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        power_cycle(boot);
        check(boot <= 2, "R8", "no replay", boot, 2);
        push_all("R8");

        finish_run();
    end

endmodule